// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into frames on an asynchronous serial line. A single holding register sits ahead of the frame shift register. Software can therefore queue the next character while the current one is still leaving, and back-to-back characters go out with no idle bit time between them. Each frame is a low start bit, 5 to 9 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The character size, parity mode and stop count are sampled when a character moves from the holding register into the shift register.

Bit timing comes from an oversample tick that an external divider supplies. Each bit lasts 16 ticks, or 8 ticks in double-speed mode. Two flags report progress. `dre` shows that the holding register can take a character. `txc` shows that the line has gone quiet after the last stop bit, with nothing left queued. A loopback control sends the serial stream to the receive-side input instead of to the pin.

Top module: `uart_buf_tx`

## Requirements
- R1: After reset, `txd` is 1, `dre` is 1 and `txc` is 0.
- R2: A frame starts with one 0 bit, followed by data bits sent LSB first. `size_sel` codes 000, 001, 010 and 011 give 5, 6, 7 and 8 bits, code 111 gives 9 bits, and every other code gives 8 bits.
- R3: `par_sel` selects the parity mode. Codes 00 and 01 send no parity bit. Code 10 sends even parity and code 11 sends odd parity. When enabled, the parity bit directly follows the last data bit and covers only the data bits of the frame.
- R4: The frame ends with one stop bit (value 1), or with two when `two_stop` is 1.
- R5: Each bit lasts 16 `os_tick` pulses, or 8 when `dbl_speed` is 1.
- R6: `dre` equals 1 exactly when the holding register is empty. A write while `dre` is 0 is dropped.
- R7: If a character is queued when the last stop bit ends, the start bit of the next frame follows with no idle time.
- R8: `txc` becomes 1 in the cycle after the last stop bit ends with the holding register empty. It stays 0 during a frame. A pulse on `txc_clr` or on `int_ack` returns it to 0.
- R9: While `tx_en` is 0, `txd` is 1, any frame in progress is abandoned, the holding register is emptied (`dre` = 1) and writes are ignored.
- R10: When `loop_en` is 1, `txd` is held at 1 and `rx_in` carries the serial stream. When `loop_en` is 0, `rx_in` follows `rxd_pin`.
- R11: In 9-bit mode, the ninth data bit sent is the value that was on `wr_bit8` during the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample tick from the external baud divider |
| tx_en | input | 1 | Transmitter enable |
| dbl_speed | input | 1 | 8 ticks per bit instead of 16 |
| size_sel | input | 3 | Character size code |
| par_sel | input | 2 | Parity mode code |
| two_stop | input | 1 | Two stop bits when 1 |
| loop_en | input | 1 | Internal loopback to the receive input |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Data bits 0 to 7 of the character |
| wr_bit8 | input | 1 | Ninth data bit of the character |
| txc_clr | input | 1 | Clears the transmit-complete flag |
| int_ack | input | 1 | Interrupt acknowledge; also clears the transmit-complete flag |
| rxd_pin | input | 1 | Serial input from the pin |
| txd | output | 1 | Serial output to the pin |
| rx_in | output | 1 | Serial stream offered to the receiver |
| dre | output | 1 | Holding register empty |
| txc | output | 1 | Transmit complete |

## Verification
The hardest case to reach from the ports is the boundary between two frames. At that point the shift register has just finished its last stop bit while the holding register is already full. The design must then reload in that same cycle, keep `txc` low, and refuse a third write. The bench reaches this state for every combination of size, parity, stop count and speed. It writes one character, writes a second one a few cycles after the first frame has started, and then tries a third write that must be dropped. It then checks that the second start bit is on the line at the first sample after the first frame ends, and that the line stays idle afterwards.

// File: rtl/uart_buf_tx.sv
module uart_buf_tx #(
  parameter int OS_FULL = 16,
  parameter int OS_HALF = 8,
  parameter int MAX_DW  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       tx_en,
  input  logic       dbl_speed,
  input  logic [2:0] size_sel,
  input  logic [1:0] par_sel,
  input  logic       two_stop,
  input  logic       loop_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_bit8,
  input  logic       txc_clr,
  input  logic       int_ack,
  input  logic       rxd_pin,
  output logic       txd,
  output logic       rx_in,
  output logic       dre,
  output logic       txc
);

  localparam int FW = MAX_DW + 4;
  localparam int BW = $clog2(FW + 1);
  localparam int TW = $clog2(OS_FULL);

  logic [MAX_DW-1:0] hold_dat;
  logic              hold_full;
  logic              busy;
  logic [FW-1:0]     sreg;
  logic [BW-1:0]     bits_left;
  logic [TW-1:0]     tcnt;
  logic              txc_q;

  logic [3:0]        dw;
  logic [MAX_DW-1:0] dsel;
  logic [FW-1:0]     frame;
  logic [BW-1:0]     flen;
  logic [TW-1:0]     tlim;
  logic              bit_end, last, load, line;

  always_comb begin
    case (size_sel)
      3'd0:    dw = 4'd5;
      3'd1:    dw = 4'd6;
      3'd2:    dw = 4'd7;
      3'd3:    dw = 4'd8;
      3'd7:    dw = 4'd9;
      default: dw = 4'd8;
    endcase
  end

  assign dsel = hold_dat & (9'h1FF >> (4'd9 - dw));

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DW; i++)
      if (i < int'(dw)) frame[1 + i] = dsel[i];
    if (par_sel[1]) frame[1 + int'(dw)] = (^dsel) ^ par_sel[0];
  end

  assign flen    = BW'(32'd2 + 32'(dw) + 32'(par_sel[1]) + 32'(two_stop));
  assign tlim    = dbl_speed ? TW'(OS_HALF - 1) : TW'(OS_FULL - 1);
  assign bit_end = busy && os_tick && (tcnt == tlim);
  assign last    = bit_end && (bits_left == BW'(1));
  assign load    = tx_en && hold_full && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_dat  <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sreg      <= '1;
      bits_left <= '0;
      tcnt      <= '0;
    end else if (!tx_en) begin
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sreg      <= '1;
      tcnt      <= '0;
    end else begin
      if (load) begin
        sreg      <= frame;
        bits_left <= flen;
        tcnt      <= '0;
        busy      <= 1'b1;
      end else if (bit_end) begin
        tcnt <= '0;
        if (last) begin
          busy <= 1'b0;
        end else begin
          sreg      <= {1'b1, sreg[FW-1:1]};
          bits_left <= bits_left - BW'(1);
        end
      end else if (busy && os_tick) begin
        tcnt <= tcnt + TW'(1);
      end

      if (load) begin
        hold_full <= 1'b0;
      end else if (wr_en && !hold_full) begin
        hold_full <= 1'b1;
        hold_dat  <= {wr_bit8, wr_data};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       txc_q <= 1'b0;
    else if (tx_en && last && !load)  txc_q <= 1'b1;
    else if (txc_clr || int_ack)      txc_q <= 1'b0;
  end

  assign line  = busy ? sreg[0] : 1'b1;
  assign txd   = loop_en ? 1'b1 : line;
  assign rx_in = loop_en ? line : rxd_pin;
  assign dre   = ~hold_full;
  assign txc   = txc_q;

  a_r7_gapless_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && last && hold_full) |=> (busy && !line));

  a_r6_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && wr_en && dre) |=> !dre);

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (line && dre));

  a_r8_txc_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> ($past(busy) && !busy && dre));

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !line);

endmodule

// File: tb/uart_buf_tx_tb.sv
module uart_buf_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [2:0] size_sel = 3'd3;
  logic [1:0] par_sel = 2'd0;
  logic       two_stop = 1'b0;
  logic       loop_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       wr_bit8 = 1'b0;
  logic       txc_clr = 1'b0;
  logic       int_ack = 1'b0;
  logic       rxd_pin = 1'b1;
  logic       txd, rx_in, dre, txc;
  logic       obs;

  int nchk = 0;
  int nfail = 0;
  int tdiv = 1;
  int tcyc = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    tcyc <= tcyc + 1;
    os_tick <= ((tcyc % tdiv) == 0);
  end

  assign obs = loop_en ? rx_in : txd;

  uart_buf_tx dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .tx_en(tx_en),
    .dbl_speed(dbl_speed), .size_sel(size_sel), .par_sel(par_sel),
    .two_stop(two_stop), .loop_en(loop_en), .wr_en(wr_en),
    .wr_data(wr_data), .wr_bit8(wr_bit8), .txc_clr(txc_clr),
    .int_ack(int_ack), .rxd_pin(rxd_pin), .txd(txd), .rx_in(rx_in),
    .dre(dre), .txc(txc)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] sz);
    if (sz < 3'd4) return 5 + int'(sz);
    if (sz == 3'd7) return 9;
    return 8;
  endfunction

  function automatic int exp_bits(input logic [8:0] d, input logic [2:0] sz,
                                  input logic [1:0] par, input logic stp,
                                  output logic [15:0] b);
    int w, n;
    logic [9:0] mm;
    w = width_of(sz);
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < w; i++) b[1 + i] = d[i];
    n = 1 + w;
    if (par[1]) begin
      mm = (10'h1 << w) - 10'h1;
      b[n] = (^(d & mm[8:0])) ^ par[0];
      n++;
    end
    n += stp ? 2 : 1;
    return n;
  endfunction

  task automatic write_char(input logic [8:0] d);
    wr_en = 1'b1;
    wr_data = d[7:0];
    wr_bit8 = d[8];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rx_frame(input logic [8:0] d, input bit gapless, input bit txc_end, input int td);
    logic [15:0] b;
    int n, w, p, g;
    string tg;
    n = exp_bits(d, size_sel, par_sel, two_stop, b);
    w = width_of(size_sel);
    p = (dbl_speed ? 8 : 16) * td;
    if (gapless) begin
      chk(obs === 1'b0, "R7 queued start bit follows without idle time", int'(obs), 0);
    end else begin
      g = 0;
      while (obs !== 1'b0 && g < 20000) begin
        @(negedge clk);
        g++;
      end
      chk(g < 20000, "R2 start bit appears", g, 0);
    end
    repeat (p / 2) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) repeat (p) @(negedge clk);
      if (k == 0) tg = "R2 start bit";
      else if (k <= w) tg = (k == 9) ? "R11 ninth data bit" : "R2 data bit";
      else if (par_sel[1] && k == w + 1) tg = "R3 parity bit";
      else tg = "R4 stop bit";
      chk(obs === b[k], tg, int'(obs), int'(b[k]));
      if (loop_en) chk(txd === 1'b1, "R10 pin held high in loopback", int'(txd), 1);
    end
    chk(txc === 1'b0, "R8 txc low during frame", int'(txc), 0);
    if (td == 1) begin
      repeat (p - p / 2 - 1) @(negedge clk);
      chk(obs === 1'b1 && txc === 1'b0, "R5 last stop bit lasts a full period", int'(txc), 0);
      @(negedge clk);
    end else begin
      repeat (p - p / 2 + td) @(negedge clk);
    end
    chk(txc === txc_end, "R8 txc at frame end", int'(txc), int'(txc_end));
  endtask

  task automatic run_pair(input logic [8:0] a, input logic [8:0] bb, input int td);
    bit idle_ok;
    int p;
    p = (dbl_speed ? 8 : 16) * td;
    txc_clr = 1'b1;
    @(negedge clk);
    txc_clr = 1'b0;
    chk(txc === 1'b0, "R8 txc_clr clears flag", int'(txc), 0);
    write_char(a);
    chk(dre === 1'b0, "R6 dre low after write", int'(dre), 0);
    fork
      rx_frame(a, 1'b0, 1'b0, td);
      begin
        repeat (4) @(negedge clk);
        write_char(bb);
        chk(dre === 1'b0, "R6 dre low with character queued", int'(dre), 0);
        write_char(~bb);
      end
    join
    rx_frame(bb, 1'b1, 1'b1, td);
    idle_ok = 1'b1;
    for (int i = 0; i < 2 * p; i++) begin
      if (obs !== 1'b1 || dre !== 1'b1) idle_ok = 1'b0;
      @(negedge clk);
    end
    chk(idle_ok, "R6 write while full was dropped", int'(idle_ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int idx;
    bit hold_ok;
    logic [8:0] da;
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && dre === 1'b1 && txc === 1'b0, "R1 state during reset", int'({txd, dre, txc}), 6);
    rst_n = 1'b1;
    tx_en = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && dre === 1'b1 && txc === 1'b0, "R1 state after reset", int'({txd, dre, txc}), 6);

    rxd_pin = 1'b0;
    @(negedge clk);
    chk(rx_in === 1'b0, "R10 rx_in follows pin", int'(rx_in), 0);
    rxd_pin = 1'b1;
    @(negedge clk);
    chk(rx_in === 1'b1, "R10 rx_in follows pin", int'(rx_in), 1);

    idx = 0;
    for (int s = 0; s < 8; s++)
      for (int pr = 0; pr < 4; pr++)
        for (int st = 0; st < 2; st++)
          for (int db = 0; db < 2; db++) begin
            size_sel = 3'(s);
            par_sel = 2'(pr);
            two_stop = st[0];
            dbl_speed = db[0];
            loop_en = ((s + pr) % 2) == 1;
            da = 9'((idx * 73 + 165) % 512);
            run_pair(da, ~da, 1);
            idx++;
          end

    chk(txc === 1'b1, "R8 txc held after last frame", int'(txc), 1);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    chk(txc === 1'b0, "R8 int_ack clears txc", int'(txc), 0);

    loop_en = 1'b0;
    size_sel = 3'd3;
    par_sel = 2'd3;
    two_stop = 1'b1;
    dbl_speed = 1'b0;
    tdiv = 3;
    repeat (4) @(negedge clk);
    run_pair(9'h0C3, 9'h15A, 3);
    tdiv = 1;
    repeat (4) @(negedge clk);

    write_char(9'h055);
    repeat (20) @(negedge clk);
    write_char(9'h0AA);
    repeat (5) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R9 line idle when disabled", int'(txd), 1);
    chk(dre === 1'b1, "R9 queued character discarded", int'(dre), 1);
    write_char(9'h0F0);
    chk(dre === 1'b1, "R9 write ignored when disabled", int'(dre), 1);
    tx_en = 1'b1;
    hold_ok = 1'b1;
    for (int i = 0; i < 48; i++) begin
      if (txd !== 1'b1 || dre !== 1'b1) hold_ok = 1'b0;
      @(negedge clk);
    end
    chk(hold_ok, "R9 no frame resumes after re-enable", int'(hold_ok), 1);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule